// File: doc/BRIEF.md
# Reset Stretcher and Strap Latch

This block turns a noisy, active-low board reset into a clean internal reset for the rest of a timing chip. It also captures two configuration strap pins while that reset is active. Everything runs on the master oscillator clock, and all intervals are counted in cycles of that clock.

A low level on the board reset is accepted only after it has stayed low for a minimum number of cycles. Shorter dips are ignored. Once the board reset returns high, the internal reset remains asserted for a long hold interval before it releases. During the whole reset period the two straps are copied into configuration bits. The first strap is the external fast-selection enable. The second is the line-rate family bit, where 1 means the 1.544 MHz family and 0 means the 2.048 MHz family. After release, the line-rate strap no longer has any effect. The fast-select strap becomes a live selector for the clock input pair of a downstream loop, but only while the enable bit is set. When the enable bit is clear, a software-written field chooses the pair instead. A small write port lets software overwrite the captured bits once reset is over.

The controller has three states:
- `ST_LOW`: a qualified low is in progress. This is also the state at power-up.
- `ST_HOLD`: the hold interval is being counted.
- `ST_RUN`: normal operation.

The transitions are:
- LOW→HOLD: taken when the synchronized board reset reads high.
- HOLD→RUN: taken when the hold count reaches its end.
- HOLD→LOW and RUN→LOW: taken when a low has been qualified.

Top module: `rst_strap_ctrl`

## Requirements
- R1: `core_rst_n` is 0 from power-up for as long as `ext_rst_n` stays 0.
- R2: When `ext_rst_n` is 0 for MIN_LOW_CYCLES consecutive cycles while out of reset, `core_rst_n` goes to 0. A low lasting MIN_LOW_CYCLES-1 cycles leaves `core_rst_n` at 1.
- R3: After `ext_rst_n` rises, `core_rst_n` rises on the (HOLD_CYCLES+3)-th rising edge. The first edge that samples the high level counts as edge 1. The extra edges are two synchronizer stages plus the LOW→HOLD step.
- R4: While `core_rst_n` is 0, `fast_sel_en` takes the level of `strap_fsel`.
- R5: While `core_rst_n` is 0, `freq_mode` takes the level of `strap_mode` (1 = 1.544 MHz family, 0 = 2.048 MHz family). After release, `strap_mode` has no effect.
- R6: Out of reset with `fast_sel_en`=1, `pair_sel` follows `strap_fsel` three cycles later at most (1 = input pair 1, 0 = input pair 2).
- R7: With `fast_sel_en`=0, `pair_sel` equals the software pair field and ignores `strap_fsel`. That field is reset to 1 (pair 1) during reset.
- R8: Out of reset, a write with `wr_en`=1 takes effect on the next edge. Address 0x0B sets `fast_sel_en` from data bit 4 and the software pair field from bit 0. Address 0x09 sets `freq_mode` from bit 2. Writes to other addresses change nothing.
- R9: Writes made while `core_rst_n` is 0 are ignored, and the strap values are kept.
- R10: A qualified low during the hold interval restarts the whole sequence. The hold count then starts again from the later rise, and the straps are re-captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock |
| ext_rst_n | input | 1 | Board reset, active low, asynchronous |
| strap_fsel | input | 1 | Fast-select strap; live pair selector after reset |
| strap_mode | input | 1 | Line-rate family strap |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| core_rst_n | output | 1 | Stretched internal reset, active low |
| fast_sel_en | output | 1 | External fast-selection enable bit |
| freq_mode | output | 1 | Line-rate family bit |
| pair_sel | output | 1 | Input pair select, 1 = pair 1, 0 = pair 2 |

## Verification
Three properties are checked on every cycle:
- The internal reset may only release out of the hold state.
- The running state is never left while the synchronized board reset is high.
- The hold counter never passes its last value, and the configuration bits never change in the running state without a write.

The following can only be shown by the directed scenarios, because they depend on counted pulse widths and stimulus history:
- The exact release edge.
- The boundary between an ignored glitch and a qualified low.
- Strap capture and write blocking during reset.
- The restart of the hold interval.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [1:0] {
        ST_LOW  = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } rsc_state_e;

    localparam logic [7:0] ADDR_SEL  = 8'h0B;
    localparam logic [7:0] ADDR_MODE = 8'h09;
    localparam int         BIT_FEN   = 4;
    localparam int         BIT_SWP   = 0;
    localparam int         BIT_MODE  = 2;

endpackage

// File: rtl/rsc_sync2.sv
module rsc_sync2 #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic out_q;
        always_ff @(posedge clk) begin
            meta_q <= d[i];
            out_q  <= meta_q;
        end
        assign q[i] = out_q;
    end
endmodule

// File: rtl/rsc_seq.sv
module rsc_seq
    import rsc_pkg::*;
#(
    parameter int MIN_LOW_CYCLES = 640,
    parameter int HOLD_CYCLES    = 6400000
) (
    input  logic clk,
    input  logic rst_s,
    output logic in_reset
);
    localparam int LW = $clog2(MIN_LOW_CYCLES + 1);
    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [LW-1:0] LOW_LAST  = LW'(MIN_LOW_CYCLES - 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

    rsc_state_e    state_q, state_d;
    logic [LW-1:0] low_q;
    logic [HW-1:0] hold_q;
    logic          low_qual;

    // a low is qualified on its MIN_LOW_CYCLES-th consecutive sample
    assign low_qual = !rst_s && (low_q == LOW_LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW:  if (rst_s) state_d = ST_HOLD;
            ST_HOLD: begin
                if (low_qual)                state_d = ST_LOW;
                else if (hold_q == HOLD_LAST) state_d = ST_RUN;
            end
            ST_RUN:  if (low_qual) state_d = ST_LOW;
            default: state_d = ST_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst_s || state_q == ST_LOW) begin
            low_q <= '0;
        end else if (low_q != LOW_LAST) begin
            low_q <= low_q + 1'b1;
        end
        if (state_q != ST_HOLD) begin
            hold_q <= '0;
        end else if (hold_q != HOLD_LAST) begin
            hold_q <= hold_q + 1'b1;
        end
    end

    always_comb begin
        in_reset = (state_q != ST_RUN);
    end

    // R3
    release_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
        $rose(state_q == ST_RUN) |-> $past(state_q) == ST_HOLD);

    // R2
    run_kept_chk: assert property (@(posedge clk) disable iff (!rst_s)
        (state_q == ST_RUN) |=> (state_q == ST_RUN));

    // R3
    hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_s)
        hold_q <= HOLD_LAST);
endmodule

// File: rtl/rsc_cfg.sv
module rsc_cfg
    import rsc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_s,
    input  logic              in_reset,
    input  logic              fsel_s,
    input  logic              mode_s,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              fast_sel_en,
    output logic              freq_mode,
    output logic              pair_sel
);
    logic fen_q, mode_q, swp_q;
    logic unused_wr_bits;

    assign unused_wr_bits = ^wr_data;

    always_ff @(posedge clk) begin
        if (in_reset) begin
            fen_q  <= fsel_s;
            mode_q <= mode_s;
            swp_q  <= 1'b1;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_SEL)) begin
                fen_q <= wr_data[BIT_FEN];
                swp_q <= wr_data[BIT_SWP];
            end
            if (wr_addr == ADDR_W'(ADDR_MODE)) begin
                mode_q <= wr_data[BIT_MODE];
            end
        end
    end

    always_comb begin
        fast_sel_en = fen_q;
        freq_mode   = mode_q;
        pair_sel    = fen_q ? fsel_s : swp_q;
    end

    // R8
    cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_s)
        (!in_reset && !wr_en) |=> ($stable(fen_q) && $stable(mode_q) && $stable(swp_q)));
endmodule

// File: rtl/rst_strap_ctrl.sv
module rst_strap_ctrl #(
    parameter int MIN_LOW_CYCLES = 640,
    parameter int HOLD_CYCLES    = 6400000,
    parameter int ADDR_W         = 8,
    parameter int DATA_W         = 8
) (
    input  logic              clk,
    input  logic              ext_rst_n,
    input  logic              strap_fsel,
    input  logic              strap_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              core_rst_n,
    output logic              fast_sel_en,
    output logic              freq_mode,
    output logic              pair_sel
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] pins_s;
    logic             rst_s, fsel_s, mode_s, in_reset;

    rsc_sync2 #(.W(NSYNC)) u_sync (
        .clk (clk),
        .d   ({ext_rst_n, strap_fsel, strap_mode}),
        .q   (pins_s)
    );

    assign {rst_s, fsel_s, mode_s} = pins_s;

    rsc_seq #(
        .MIN_LOW_CYCLES (MIN_LOW_CYCLES),
        .HOLD_CYCLES    (HOLD_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst_s    (rst_s),
        .in_reset (in_reset)
    );

    rsc_cfg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cfg (
        .clk         (clk),
        .rst_s       (rst_s),
        .in_reset    (in_reset),
        .fsel_s      (fsel_s),
        .mode_s      (mode_s),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .fast_sel_en (fast_sel_en),
        .freq_mode   (freq_mode),
        .pair_sel    (pair_sel)
    );

    assign core_rst_n = !in_reset;
endmodule

// File: tb/tb_rst_strap_ctrl.sv
module tb_rst_strap_ctrl;
    localparam int MINL = 8;
    localparam int HOLD = 20;

    logic       clk = 1'b0;
    logic       ext_rst_n, strap_fsel, strap_mode, wr_en;
    logic [7:0] wr_addr, wr_data;
    logic       core_rst_n, fast_sel_en, freq_mode, pair_sel;
    int         checks = 0;
    int         errors = 0;

    always #2 clk = ~clk;

    rst_strap_ctrl #(
        .MIN_LOW_CYCLES (MINL),
        .HOLD_CYCLES    (HOLD),
        .ADDR_W         (8),
        .DATA_W         (8)
    ) dut (
        .clk (clk), .ext_rst_n (ext_rst_n), .strap_fsel (strap_fsel),
        .strap_mode (strap_mode), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .core_rst_n (core_rst_n), .fast_sel_en (fast_sel_en),
        .freq_mode (freq_mode), .pair_sel (pair_sel)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        cyc(1);
        wr_en = 1'b0;
        cyc(1);
    endtask

    // R3: release lands exactly HOLD+3 edges after the rise
    task automatic release_and_check(input string req);
        ext_rst_n = 1'b1;
        cyc(2 + HOLD);
        chk(req, "core_rst_n one cycle before release", core_rst_n, 1'b0);
        cyc(1);
        chk(req, "core_rst_n at release", core_rst_n, 1'b1);
    endtask

    task automatic t_powerup();
        ext_rst_n = 1'b0; strap_fsel = 1'b1; strap_mode = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        cyc(6);
        chk("R1", "core_rst_n held at power-up", core_rst_n, 1'b0);
        chk("R4", "fast_sel_en during reset", fast_sel_en, 1'b1);
        release_and_check("R3");
        chk("R4", "fast_sel_en latched", fast_sel_en, 1'b1);
        chk("R5", "freq_mode latched", freq_mode, 1'b0);
        chk("R6", "pair_sel with strap high", pair_sel, 1'b1);
    endtask

    task automatic t_fast_follow();
        strap_fsel = 1'b0; cyc(3);
        chk("R6", "pair_sel follows low strap", pair_sel, 1'b0);
        strap_fsel = 1'b1; cyc(3);
        chk("R6", "pair_sel follows high strap", pair_sel, 1'b1);
        strap_mode = 1'b1; cyc(3);
        chk("R5", "freq_mode ignores strap after reset", freq_mode, 1'b0);
        strap_mode = 1'b0; cyc(1);
    endtask

    task automatic t_writes();
        wr(8'h0B, 8'h00);
        chk("R8", "fast_sel_en cleared by write", fast_sel_en, 1'b0);
        chk("R8", "sw pair field 0", pair_sel, 1'b0);
        strap_fsel = 1'b0; cyc(3); strap_fsel = 1'b1; cyc(3);
        chk("R7", "pair_sel ignores strap when disabled", pair_sel, 1'b0);
        wr(8'h0B, 8'h01);
        chk("R7", "pair_sel from sw field", pair_sel, 1'b1);
        wr(8'h09, 8'h04);
        chk("R8", "freq_mode set by write", freq_mode, 1'b1);
        wr(8'h0A, 8'hFF);
        chk("R8", "other address fast_sel_en", fast_sel_en, 1'b0);
        chk("R8", "other address freq_mode", freq_mode, 1'b1);
        chk("R8", "other address pair_sel", pair_sel, 1'b1);
        wr(8'h09, 8'h00);
        chk("R8", "freq_mode cleared by write", freq_mode, 1'b0);
        wr(8'h0B, 8'h10);
        chk("R8", "fast_sel_en set by write", fast_sel_en, 1'b1);
        strap_fsel = 1'b0; cyc(3);
        chk("R6", "pair_sel live again", pair_sel, 1'b0);
        strap_fsel = 1'b1; cyc(1);
    endtask

    task automatic t_glitch();
        ext_rst_n = 1'b0; cyc(MINL - 1);
        ext_rst_n = 1'b1;
        for (int i = 0; i < MINL + 6; i++) begin
            cyc(1);
            chk("R2", "short low ignored", core_rst_n, 1'b1);
        end
    endtask

    task automatic t_full_pulse();
        strap_fsel = 1'b0; strap_mode = 1'b1;
        ext_rst_n = 1'b0; cyc(MINL + 3);
        chk("R2", "qualified low asserts reset", core_rst_n, 1'b0);
        wr(8'h09, 8'h00);
        wr(8'h0B, 8'h11);
        release_and_check("R3");
        chk("R9", "write in reset ignored, fast_sel_en", fast_sel_en, 1'b0);
        chk("R9", "write in reset ignored, freq_mode", freq_mode, 1'b1);
        chk("R7", "sw pair default is pair 1", pair_sel, 1'b1);
    endtask

    task automatic t_restart();
        strap_fsel = 1'b0; strap_mode = 1'b0;
        ext_rst_n = 1'b0; cyc(MINL + 2);
        ext_rst_n = 1'b1; cyc(5);
        strap_fsel = 1'b1;
        ext_rst_n = 1'b0; cyc(MINL + 2);
        release_and_check("R10");
        chk("R10", "fast_sel_en re-captured", fast_sel_en, 1'b1);
        chk("R10", "freq_mode re-captured", freq_mode, 1'b0);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_powerup();
        t_fast_follow();
        t_writes();
        t_glitch();
        t_full_pulse();
        t_restart();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule